// File: doc/BRIEF.md
# I/O Port Decode Mask Filter

This block decides, for every CPU I/O cycle, whether one of the on-chip port groups answers the cycle or whether the cycle goes out on the expansion bus. It stores two 32-bit vectors. One is an internal-device enable vector, written as four byte registers. The other is an expansion decode mask, also written as four bytes. Both are reached through an index/data register interface. Bits 15:8 of each vector control eight port groups. The incoming 16-bit port address is matched against those groups.

While the expansion bus is off, only the enable vector gates each group, and cycles never leave the chip. While the bus is on, the mask is ANDed with the enables, and a cycle that no enabled group claims is forwarded to the bus. The mask can survive a soft reset: this happens when bit 31 of the enable vector is set.

Top module: `io_decode_filter`

## Requirements
- R1: Enable vector bytes sit at indices 0x82..0x85 and mask bytes at 0x86..0x89, with index base+k holding vector bits 8k+7:8k. `reg_rdata` shows the addressed byte combinationally. Any other index reads 0x00.
- R2: A write with `reg_wr`=1 and `reg_copro`=0 updates the addressed byte at the next rising clock edge.
- R3: A write with `reg_copro`=1 to any index above 0x7F changes no register.
- R4: While `rst_n` is low, both vectors are all ones.
- R5: A `soft_rst` cycle leaves the enable vector unchanged and ignores any register write in that cycle. It sets the mask to all ones if enable bit 31 (index 0x85 bit 7) is 0, and keeps the mask if that bit is 1.
- R6: Group g uses vector bit 8+g. The groups are as follows. g0 is low byte 0xE3. g1 is a full match of `prog_port_a` or `prog_port_b`. g2 is 0x103B or 0x113B. g3 is low byte 0xE7 or 0xEB. g4 is 0x133B, 0x143B or 0x153B. g5 is 0xFADF, 0xFBDF or 0xFFDF. g6 is low byte 0x57 or 0x5B, or the full address 0x303B. g7 is 0x123B. A group listed as "low byte" compares `io_addr[7:0]` only.
- R7: The effective enable is enable AND mask while `bus_on`=1, and the enable alone while `bus_on`=0. `int_sel[g]` is 1 exactly when `io_req`=1, group g decides the address, and its effective bit is 1.
- R8: `expand_fwd` is 1 exactly when `io_req`=1, `bus_on`=1 and no `int_sel` bit is set. This covers both unmatched addresses and disabled groups. With `bus_on`=0 it stays 0.
- R9: `int_sel` has at most one bit set and is never 1 together with `expand_fwd`. Both outputs are 0 while `io_req`=0.
- R10: When an address matches several groups, the lowest-numbered matching group alone decides the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, asynchronous, active low |
| soft_rst | input | 1 | Soft reset, synchronous, active high |
| reg_idx | input | 8 | Register index |
| reg_wr | input | 1 | Register write strobe |
| reg_copro | input | 1 | Access originates from the display co-processor |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Byte at `reg_idx` |
| bus_on | input | 1 | Expansion bus enabled |
| io_req | input | 1 | CPU I/O cycle qualifier |
| io_addr | input | 16 | I/O port address |
| prog_port_a | input | 16 | First programmable port of group 1 |
| prog_port_b | input | 16 | Second programmable port of group 1 |
| int_sel | output | 8 | One-hot internal group claim |
| expand_fwd | output | 1 | Forward cycle to expansion bus |

## Verification
The assertions check four things on every cycle. `int_sel` is one-hot or zero and never appears with `expand_fwd`. Nothing is driven without `io_req`, and nothing is forwarded while the bus is off. Co-processor writes and soft resets have the required effect on the stored vectors. The bench's scenarios are the only place that shows the address-to-group table, the AND with the mask applied only while the bus is on, lowest-group priority when a programmable port overlaps a fixed one, and the hard-reset values. A cycle-level reference model runs alongside to compare read data and both outputs on every clock.

// File: rtl/iodm_pkg.sv
package iodm_pkg;

   localparam int unsigned GROUP_COUNT = 8;
   localparam int unsigned PORT_W      = 16;

   typedef enum logic [2:0] {
      GRP_CTL_E3  = 3'd0,
      GRP_PROG    = 3'd1,
      GRP_CFG     = 3'd2,
      GRP_SERIAL  = 3'd3,
      GRP_UART    = 3'd4,
      GRP_SOUND   = 3'd5,
      GRP_VIDEO   = 3'd6,
      GRP_SELECT  = 3'd7
   } grp_e;

   typedef logic [PORT_W-1:0] port_t;

   // Fixed-address match for one group; group GRP_PROG is handled elsewhere.
   function automatic logic fixed_hit(input int unsigned grp, input port_t a);
      logic [7:0] lo;
      lo = a[7:0];
      case (grp)
         0: fixed_hit = (lo == 8'hE3);
         2: fixed_hit = (a == 16'h103B) || (a == 16'h113B);
         3: fixed_hit = (lo == 8'hE7) || (lo == 8'hEB);
         4: fixed_hit = (a == 16'h133B) || (a == 16'h143B) || (a == 16'h153B);
         5: fixed_hit = (a == 16'hFADF) || (a == 16'hFBDF) || (a == 16'hFFDF);
         6: fixed_hit = (lo == 8'h57) || (lo == 8'h5B) || (a == 16'h303B);
         7: fixed_hit = (a == 16'h123B);
         default: fixed_hit = 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/iodm_regfile.sv
module iodm_regfile #(
   parameter int unsigned IDX_W         = 8,
   parameter int unsigned NUM_BYTES     = 4,
   parameter int unsigned EN_BASE       = 'h82,
   parameter int unsigned MASK_BASE     = 'h86,
   parameter int unsigned PROTECT_LIMIT = 'h7F,
   parameter int unsigned KEEP_BIT      = 31
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   soft_rst,
   input  logic [IDX_W-1:0]       reg_idx,
   input  logic                   reg_wr,
   input  logic                   reg_copro,
   input  logic [7:0]             reg_wdata,
   output logic [7:0]             reg_rdata,
   output logic [NUM_BYTES*8-1:0] en_q,
   output logic [NUM_BYTES*8-1:0] mask_q
);

   localparam int unsigned VEC_W   = NUM_BYTES * 8;
   localparam int unsigned IDX_MAX = (1 << IDX_W) - 1;

   if (NUM_BYTES < 1) begin : g_bad_bytes
      $error("iodm_regfile: NUM_BYTES must be at least 1");
   end
   if (KEEP_BIT >= VEC_W) begin : g_bad_keep
      $error("iodm_regfile: KEEP_BIT outside the enable vector");
   end
   if (EN_BASE + NUM_BYTES - 1 > IDX_MAX || MASK_BASE + NUM_BYTES - 1 > IDX_MAX) begin : g_bad_range
      $error("iodm_regfile: register window exceeds index space");
   end
   if (!(EN_BASE + NUM_BYTES <= MASK_BASE || MASK_BASE + NUM_BYTES <= EN_BASE)) begin : g_bad_overlap
      $error("iodm_regfile: enable and mask windows overlap");
   end

   logic protected_wr;
   logic wr_ok;
   logic keep_mask;

   assign protected_wr = reg_copro && (int'(reg_idx) > int'(PROTECT_LIMIT));
   assign wr_ok        = reg_wr && !soft_rst && !protected_wr;
   assign keep_mask    = en_q[KEEP_BIT];

   for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
      logic       en_sel;
      logic       mask_sel;
      logic [7:0] en_b;
      logic [7:0] mask_b;

      assign en_sel   = (reg_idx == IDX_W'(EN_BASE + b));
      assign mask_sel = (reg_idx == IDX_W'(MASK_BASE + b));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            en_b <= 8'hFF;
         end else if (wr_ok && en_sel) begin
            en_b <= reg_wdata;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mask_b <= 8'hFF;
         end else if (soft_rst) begin
            if (!keep_mask) begin
               mask_b <= 8'hFF;
            end
         end else if (wr_ok && mask_sel) begin
            mask_b <= reg_wdata;
         end
      end

      assign en_q[b*8 +: 8]   = en_b;
      assign mask_q[b*8 +: 8] = mask_b;
   end

   always_comb begin
      reg_rdata = 8'h00;
      for (int unsigned k = 0; k < NUM_BYTES; k++) begin
         if (reg_idx == IDX_W'(EN_BASE + k)) begin
            reg_rdata = en_q[k*8 +: 8];
         end
         if (reg_idx == IDX_W'(MASK_BASE + k)) begin
            reg_rdata = mask_q[k*8 +: 8];
         end
      end
   end

endmodule

// File: rtl/iodm_port_match.sv
module iodm_port_match #(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned NUM_GROUPS = 8
) (
   input  logic [ADDR_W-1:0]     io_addr,
   input  logic [ADDR_W-1:0]     prog_port_a,
   input  logic [ADDR_W-1:0]     prog_port_b,
   output logic [NUM_GROUPS-1:0] hit
);

   if (ADDR_W != iodm_pkg::PORT_W) begin : g_bad_addr
      $error("iodm_port_match: ADDR_W must equal the 16-bit port width");
   end
   if (NUM_GROUPS != iodm_pkg::GROUP_COUNT) begin : g_bad_groups
      $error("iodm_port_match: NUM_GROUPS must match the group table");
   end

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      if (g == int'(iodm_pkg::GRP_PROG)) begin : g_prog
         assign hit[g] = (io_addr == prog_port_a) || (io_addr == prog_port_b);
      end else begin : g_fixed
         assign hit[g] = iodm_pkg::fixed_hit(g, io_addr);
      end
   end

endmodule

// File: rtl/iodm_claim.sv
module iodm_claim #(
   parameter int unsigned NUM_GROUPS = 8,
   parameter bit          LOW_FIRST  = 1'b1
) (
   input  logic                  io_req,
   input  logic                  bus_on,
   input  logic [NUM_GROUPS-1:0] hit,
   input  logic [NUM_GROUPS-1:0] en_grp,
   input  logic [NUM_GROUPS-1:0] mask_grp,
   output logic [NUM_GROUPS-1:0] int_sel,
   output logic                  expand_fwd
);

   logic [NUM_GROUPS-1:0] eff;
   logic [NUM_GROUPS-1:0] winner;
   logic [NUM_GROUPS-1:0] claim;

   assign eff = bus_on ? (en_grp & mask_grp) : en_grp;

   if (LOW_FIRST) begin : g_low_first
      always_comb begin
         logic found;
         found  = 1'b0;
         winner = '0;
         for (int unsigned i = 0; i < NUM_GROUPS; i++) begin
            if (!found && hit[i]) begin
               winner[i] = 1'b1;
               found     = 1'b1;
            end
         end
      end
   end else begin : g_high_first
      always_comb begin
         logic found;
         found  = 1'b0;
         winner = '0;
         for (int i = NUM_GROUPS - 1; i >= 0; i--) begin
            if (!found && hit[i]) begin
               winner[i] = 1'b1;
               found     = 1'b1;
            end
         end
      end
   end

   assign claim      = winner & eff;
   assign int_sel    = io_req ? claim : '0;
   assign expand_fwd = io_req && bus_on && (claim == '0);

endmodule

// File: rtl/io_decode_filter.sv
module io_decode_filter #(
   parameter int unsigned ADDR_W        = 16,
   parameter int unsigned IDX_W         = 8,
   parameter int unsigned NUM_BYTES     = 4,
   parameter int unsigned NUM_GROUPS    = 8,
   parameter int unsigned GROUP_LSB     = 8,
   parameter int unsigned EN_BASE       = 'h82,
   parameter int unsigned MASK_BASE     = 'h86,
   parameter int unsigned PROTECT_LIMIT = 'h7F,
   parameter int unsigned KEEP_BIT      = 31,
   parameter bit          LOW_FIRST     = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  soft_rst,
   input  logic [IDX_W-1:0]      reg_idx,
   input  logic                  reg_wr,
   input  logic                  reg_copro,
   input  logic [7:0]            reg_wdata,
   output logic [7:0]            reg_rdata,
   input  logic                  bus_on,
   input  logic                  io_req,
   input  logic [ADDR_W-1:0]     io_addr,
   input  logic [ADDR_W-1:0]     prog_port_a,
   input  logic [ADDR_W-1:0]     prog_port_b,
   output logic [NUM_GROUPS-1:0] int_sel,
   output logic                  expand_fwd
);

   localparam int unsigned VEC_W = NUM_BYTES * 8;

   if (GROUP_LSB + NUM_GROUPS > VEC_W) begin : g_bad_slice
      $error("io_decode_filter: group slice exceeds vector width");
   end

   logic [VEC_W-1:0]      en_q;
   logic [VEC_W-1:0]      mask_q;
   logic [NUM_GROUPS-1:0] hit;

   iodm_regfile #(
      .IDX_W         (IDX_W),
      .NUM_BYTES     (NUM_BYTES),
      .EN_BASE       (EN_BASE),
      .MASK_BASE     (MASK_BASE),
      .PROTECT_LIMIT (PROTECT_LIMIT),
      .KEEP_BIT      (KEEP_BIT)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .soft_rst  (soft_rst),
      .reg_idx   (reg_idx),
      .reg_wr    (reg_wr),
      .reg_copro (reg_copro),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .en_q      (en_q),
      .mask_q    (mask_q)
   );

   iodm_port_match #(
      .ADDR_W     (ADDR_W),
      .NUM_GROUPS (NUM_GROUPS)
   ) u_match (
      .io_addr     (io_addr),
      .prog_port_a (prog_port_a),
      .prog_port_b (prog_port_b),
      .hit         (hit)
   );

   iodm_claim #(
      .NUM_GROUPS (NUM_GROUPS),
      .LOW_FIRST  (LOW_FIRST)
   ) u_claim (
      .io_req     (io_req),
      .bus_on     (bus_on),
      .hit        (hit),
      .en_grp     (en_q[GROUP_LSB +: NUM_GROUPS]),
      .mask_grp   (mask_q[GROUP_LSB +: NUM_GROUPS]),
      .int_sel    (int_sel),
      .expand_fwd (expand_fwd)
   );

endmodule

// File: rtl/iodm_filter_chk.sv
module iodm_filter_chk #(
   parameter int unsigned IDX_W         = 8,
   parameter int unsigned NUM_GROUPS    = 8,
   parameter int unsigned VEC_W         = 32,
   parameter int unsigned PROTECT_LIMIT = 'h7F,
   parameter int unsigned KEEP_BIT      = 31
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  soft_rst,
   input logic                  reg_wr,
   input logic                  reg_copro,
   input logic [IDX_W-1:0]      reg_idx,
   input logic                  bus_on,
   input logic                  io_req,
   input logic [NUM_GROUPS-1:0] int_sel,
   input logic                  expand_fwd,
   input logic [VEC_W-1:0]      en_q,
   input logic [VEC_W-1:0]      mask_q
);

   assert_sel_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(int_sel));

   assert_sel_fwd_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(expand_fwd && (int_sel != '0)));

   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !io_req |-> (int_sel == '0) && !expand_fwd);

   assert_no_fwd_bus_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_on |-> !expand_fwd);

   assert_copro_blocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_copro && !soft_rst && (int'(reg_idx) > int'(PROTECT_LIMIT)))
      |=> $stable(en_q) && $stable(mask_q));

   assert_soft_refill_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (soft_rst && !en_q[KEEP_BIT]) |=> (mask_q == '1));

   assert_soft_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (soft_rst && en_q[KEEP_BIT]) |=> $stable(mask_q) && $stable(en_q));

endmodule

bind io_decode_filter iodm_filter_chk #(
   .IDX_W         (IDX_W),
   .NUM_GROUPS    (NUM_GROUPS),
   .VEC_W         (NUM_BYTES * 8),
   .PROTECT_LIMIT (PROTECT_LIMIT),
   .KEEP_BIT      (KEEP_BIT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .soft_rst   (soft_rst),
   .reg_wr     (reg_wr),
   .reg_copro  (reg_copro),
   .reg_idx    (reg_idx),
   .bus_on     (bus_on),
   .io_req     (io_req),
   .int_sel    (int_sel),
   .expand_fwd (expand_fwd),
   .en_q       (en_q),
   .mask_q     (mask_q)
);

// File: tb/tb_io_decode_filter.sv
`timescale 1ns/1ps
module tb_io_decode_filter;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        soft_rst = 1'b0;
   logic [7:0]  reg_idx = 8'h00;
   logic        reg_wr = 1'b0;
   logic        reg_copro = 1'b0;
   logic [7:0]  reg_wdata = 8'h00;
   logic [7:0]  reg_rdata;
   logic        bus_on = 1'b0;
   logic        io_req = 1'b0;
   logic [15:0] io_addr = 16'h0000;
   logic [15:0] prog_port_a = 16'h1F00;
   logic [15:0] prog_port_b = 16'h2F00;
   logic [7:0]  int_sel;
   logic        expand_fwd;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   io_decode_filter dut (
      .clk (clk), .rst_n (rst_n), .soft_rst (soft_rst),
      .reg_idx (reg_idx), .reg_wr (reg_wr), .reg_copro (reg_copro),
      .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
      .bus_on (bus_on), .io_req (io_req), .io_addr (io_addr),
      .prog_port_a (prog_port_a), .prog_port_b (prog_port_b),
      .int_sel (int_sel), .expand_fwd (expand_fwd)
   );

   // ---------------- reference model ----------------
   logic [7:0] m_en   [4];
   logic [7:0] m_mask [4];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 4; i++) begin
            m_en[i]   <= 8'hFF;
            m_mask[i] <= 8'hFF;
         end
      end else if (soft_rst) begin
         if (m_en[3][7] == 1'b0) begin
            for (int i = 0; i < 4; i++) m_mask[i] <= 8'hFF;
         end
      end else if (reg_wr && !(reg_copro && reg_idx > 8'h7F)) begin
         if (reg_idx >= 8'h82 && reg_idx <= 8'h85) m_en[reg_idx - 8'h82] <= reg_wdata;
         if (reg_idx >= 8'h86 && reg_idx <= 8'h89) m_mask[reg_idx - 8'h86] <= reg_wdata;
      end
   end

   function automatic int model_group(input logic [15:0] a);
      if (a[7:0] == 8'hE3) return 0;
      if (a == prog_port_a || a == prog_port_b) return 1;
      if (a == 16'h103B || a == 16'h113B) return 2;
      if (a[7:0] == 8'hE7 || a[7:0] == 8'hEB) return 3;
      if (a == 16'h133B || a == 16'h143B || a == 16'h153B) return 4;
      if (a == 16'hFADF || a == 16'hFBDF || a == 16'hFFDF) return 5;
      if (a[7:0] == 8'h57 || a[7:0] == 8'h5B || a == 16'h303B) return 6;
      if (a == 16'h123B) return 7;
      return -1;
   endfunction

   function automatic logic [7:0] model_rdata(input logic [7:0] idx);
      if (idx >= 8'h82 && idx <= 8'h85) return m_en[idx - 8'h82];
      if (idx >= 8'h86 && idx <= 8'h89) return m_mask[idx - 8'h86];
      return 8'h00;
   endfunction

   function automatic logic [7:0] model_sel();
      int g;
      logic on;
      g = model_group(io_addr);
      if (!io_req || g < 0) return 8'h00;
      on = m_en[1][g];
      if (bus_on) on = on & m_mask[1][g];
      return on ? (8'h01 << g) : 8'h00;
   endfunction

   // ---------------- checking ----------------
   task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R1 cycle rdata", {8'h00, reg_rdata}, {8'h00, model_rdata(reg_idx)});
         chk("R7 cycle int_sel", {8'h00, int_sel}, {8'h00, model_sel()});
         chk("R8 cycle expand_fwd", {15'h0, expand_fwd},
             {15'h0, io_req && bus_on && (model_sel() == 8'h00)});
      end
   end

   task automatic wr(input logic [7:0] idx, input logic [7:0] data, input logic cp);
      reg_idx = idx; reg_wdata = data; reg_copro = cp; reg_wr = 1'b1;
      @(posedge clk); #1;
      reg_wr = 1'b0; reg_copro = 1'b0;
   endtask

   task automatic rd_chk(input string tag, input logic [7:0] idx, input logic [7:0] exp);
      reg_idx = idx;
      @(negedge clk);
      chk(tag, {8'h00, reg_rdata}, {8'h00, exp});
   endtask

   task automatic io_chk(input string tag, input logic [15:0] a,
                         input logic [7:0] exp_sel, input logic exp_fwd);
      io_addr = a; io_req = 1'b1;
      @(negedge clk);
      chk({tag, " sel"}, {8'h00, int_sel}, {8'h00, exp_sel});
      chk({tag, " fwd"}, {15'h0, expand_fwd}, {15'h0, exp_fwd});
      io_req = 1'b0;
   endtask

   task automatic soft_pulse(input bit with_write, input logic [7:0] idx, input logic [7:0] data);
      soft_rst = 1'b1;
      if (with_write) begin
         reg_idx = idx; reg_wdata = data; reg_wr = 1'b1;
      end
      @(posedge clk); #1;
      soft_rst = 1'b0; reg_wr = 1'b0;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      #(4 * 100000);
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R4: reset values
      rd_chk("R4 reset mask 0x87", 8'h87, 8'hFF);
      rd_chk("R4 reset enable 0x82", 8'h82, 8'hFF);
      rd_chk("R1 unmapped index 0x80", 8'h80, 8'h00);

      // R6: group table, bus off, all enabled
      io_chk("R6 g0 xxE3", 16'h12E3, 8'h01, 1'b0);
      io_chk("R6 g1 prog b", 16'h2F00, 8'h02, 1'b0);
      io_chk("R6 g2 113B", 16'h113B, 8'h04, 1'b0);
      io_chk("R6 g3 xxEB", 16'h00EB, 8'h08, 1'b0);
      io_chk("R6 g4 143B", 16'h143B, 8'h10, 1'b0);
      io_chk("R6 g5 FBDF", 16'hFBDF, 8'h20, 1'b0);
      io_chk("R6 g6 xx57", 16'hAA57, 8'h40, 1'b0);
      io_chk("R6 g6 303B", 16'h303B, 8'h40, 1'b0);
      io_chk("R6 g7 123B", 16'h123B, 8'h80, 1'b0);
      io_chk("R8 unmatched bus off", 16'h0000, 8'h00, 1'b0);
      bus_on = 1'b1;
      io_chk("R8 unmatched bus on", 16'h0000, 8'h00, 1'b1);
      io_chk("R6 full compare 223B", 16'h223B, 8'h00, 1'b1);

      // R9: no request
      io_addr = 16'h123B; io_req = 1'b0;
      @(negedge clk);
      chk("R9 idle sel", {8'h00, int_sel}, 16'h0000);
      chk("R9 idle fwd", {15'h0, expand_fwd}, 16'h0000);

      // R2 / R7: mask cleared
      wr(8'h87, 8'h00, 1'b0);
      rd_chk("R2 mask write 0x87", 8'h87, 8'h00);
      io_chk("R7 masked bus on", 16'h123B, 8'h00, 1'b1);
      bus_on = 1'b0;
      io_chk("R7 mask ignored bus off", 16'h123B, 8'h80, 1'b0);

      // R3: co-processor write rejected
      wr(8'h87, 8'h5A, 1'b1);
      rd_chk("R3 copro write 0x87", 8'h87, 8'h00);
      wr(8'h83, 8'h11, 1'b1);
      rd_chk("R3 copro write 0x83", 8'h83, 8'hFF);

      // R7 / R8: combined enable and mask
      wr(8'h83, 8'hF0, 1'b0);
      wr(8'h87, 8'h3C, 1'b0);
      bus_on = 1'b1;
      io_chk("R7 eff g4", 16'h143B, 8'h10, 1'b0);
      io_chk("R8 disabled g2 forwarded", 16'h113B, 8'h00, 1'b1);
      io_chk("R8 mask-off g7 forwarded", 16'h123B, 8'h00, 1'b1);
      bus_on = 1'b0;
      io_chk("R7 g7 bus off", 16'h123B, 8'h80, 1'b0);
      io_chk("R8 disabled g2 blocked", 16'h113B, 8'h00, 1'b0);

      // R10: programmable port overlapping group 0
      wr(8'h87, 8'hFF, 1'b0);
      wr(8'h83, 8'hFE, 1'b0);
      prog_port_a = 16'h00E3;
      bus_on = 1'b1;
      io_chk("R10 g0 off decides", 16'h00E3, 8'h00, 1'b1);
      wr(8'h83, 8'hFD, 1'b0);
      io_chk("R10 g0 on wins", 16'h00E3, 8'h01, 1'b0);
      prog_port_a = 16'h1F00;

      // R5: soft reset behaviour
      wr(8'h86, 8'h12, 1'b0);
      soft_pulse(1'b0, 8'h00, 8'h00);
      rd_chk("R5 keep bit set mask kept", 8'h86, 8'h12);
      soft_pulse(1'b1, 8'h84, 8'h00);
      rd_chk("R5 write during soft ignored", 8'h84, 8'hFF);
      wr(8'h85, 8'h7F, 1'b0);
      soft_pulse(1'b0, 8'h00, 8'h00);
      rd_chk("R5 keep bit clear mask refilled", 8'h86, 8'hFF);
      rd_chk("R5 enables untouched", 8'h85, 8'h7F);

      // R4: hard reset mid-run
      wr(8'h88, 8'h00, 1'b0);
      rd_chk("R2 mask write 0x88", 8'h88, 8'h00);
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      #1 rst_n = 1'b1;
      rd_chk("R4 hard reset mask 0x88", 8'h88, 8'hFF);
      rd_chk("R4 hard reset enable 0x85", 8'h85, 8'hFF);
      rd_chk("R4 hard reset enable 0x83", 8'h83, 8'hFF);

      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule